// File: doc/BRIEF.md
# Block-Paced DMA Write Request Controller

This block paces a system DMA engine that fills the transmit buffer of an SD/SDIO host controller during block writes. Once a write command has started, it raises one active-low request for each data block, but only when the buffer has room for a whole block. It drops the request when the first 32-bit word arrives. The DMA engine then delivers the rest of the block in one run or in several bursts, with no further request. The block counts the words written, and it holds back the next request until the current block is complete and a full block of free space exists again.

The card-side logic is reduced to three strobes. One removes a word from the buffer. One reports the command response. One reports the end of the card's CRC status and busy period. The block keeps a write-transfer-active flag and two sticky event flags: command complete and transfer complete. Each event flag is cleared by writing a one to its clear input. A programmable block count covers both single-block and multi-block writes.

Top module: `dma_wreq_ctrl`

## Requirements
- R1: After reset, `dma_req_n` is high, `xfer_active` is low, `buf_level` is 0 and both event flags are low.
- R2: The words per block are ceil(`cfg_blk_bytes`/4), and a value of 0 bytes counts as 1 word. A request (`dma_req_n` low) is raised only while `DEPTH - buf_level` is at least the words per block. After a write command is accepted with enough space, `dma_req_n` goes low two clock edges after the edge that samples `cmd_start`.
- R3: `dma_req_n` returns high at the edge that accepts the first word of the block. There is exactly one request per block.
- R4: A new request stays masked until exactly the words per block have been accepted. If space allows, the next request goes low at the edge after the one that accepts the block's last word.
- R5: While the free space is smaller than the words per block, no request is raised. The request is raised one edge after a drain makes enough room.
- R6: `buf_level` rises by 1 for each accepted word and falls by 1 for each `drain` strobe while it is non-zero. It never exceeds `DEPTH`, and a drain while it is 0 leaves it at 0.
- R7: A `wr_valid` strobe is ignored when no block request is outstanding or in progress, and `buf_level` does not change.
- R8: `xfer_active` rises one edge after `cmd_start` is sampled while idle, and it falls one edge after `xfer_done`. A request is only ever raised while `xfer_active` is high.
- R9: After `cfg_blk_count` blocks have been requested, no further request is raised in that transfer. A count of 0 raises no request.
- R10: `irq_cmd_done` is set by `cmd_resp` and `irq_xfer_done` by `xfer_done`, each only while `xfer_active` is high. Both flags are sticky. `irq_clr[0]` clears the command flag and `irq_clr[1]` clears the transfer flag. A set in the same cycle as a clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_blk_bytes | input | 11 | Bytes per block |
| cfg_blk_count | input | CNT_W | Number of blocks in the transfer |
| cmd_start | input | 1 | Write command issued (strobe) |
| cmd_resp | input | 1 | Command response received (strobe) |
| wr_valid | input | 1 | DMA writes one 32-bit word (strobe) |
| drain | input | 1 | Card side removes one word (strobe) |
| xfer_done | input | 1 | Card CRC status and busy period ended (strobe) |
| irq_clr | input | 2 | Write-one-to-clear: bit 0 command flag, bit 1 transfer flag |
| dma_req_n | output | 1 | Active-low DMA write request |
| xfer_active | output | 1 | Write transfer in progress |
| buf_level | output | LVL_W | Words held in the buffer |
| irq_cmd_done | output | 1 | Sticky command-complete flag |
| irq_xfer_done | output | 1 | Sticky transfer-complete flag |

## Verification
The hardest situation to reach is a block that has finished arriving while the buffer is still too full for the next one. In that state the word-count mask has lifted but the space mask has not. The bench uses a buffer only eight words deep and blocks of ten bytes, which round up to three words. After two blocks the free space is two words, so the request must stay high. A single drain strobe then frees enough room, and the bench checks that the request appears exactly one edge later. Word counts that stop just short of a block, and writes that arrive once all blocks have been requested, exercise the exact-count mask and the ignored-write path.

// File: rtl/dma_wreq_pkg.sv
package dma_wreq_pkg;
  localparam int BLEN_W = 11;
  localparam int WRD_W  = BLEN_W - 1;

  // Words of 32 bits needed for a block, rounded up; zero bytes counts as one word.
  function automatic logic [WRD_W-1:0] blk_words(input logic [BLEN_W-1:0] nbytes);
    logic [BLEN_W:0] padded;
    padded = {1'b0, nbytes} + 3;
    if (padded[BLEN_W:2] == '0) blk_words = 1;
    else                        blk_words = padded[BLEN_W:2];
  endfunction
endpackage

// File: rtl/dma_wreq_status.sv
module dma_wreq_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_start,
  input  logic       cmd_resp,
  input  logic       xfer_done,
  input  logic [1:0] irq_clr,
  output logic       start_ok,
  output logic       stop_ok,
  output logic       active,
  output logic       irq_cmd,
  output logic       irq_xfer
);
  logic active_q, active_d;
  logic cmd_q, cmd_d;
  logic xfr_q, xfr_d;
  logic en;

  assign start_ok = cmd_start & ~active_q;
  assign stop_ok  = xfer_done & active_q;

  always_comb begin
    active_d = active_q;
    if (start_ok)     active_d = 1'b1;
    else if (stop_ok) active_d = 1'b0;

    cmd_d = cmd_q;
    if (irq_clr[0])              cmd_d = 1'b0;
    if (cmd_resp && active_q)    cmd_d = 1'b1;

    xfr_d = xfr_q;
    if (irq_clr[1])              xfr_d = 1'b0;
    if (stop_ok)                 xfr_d = 1'b1;
  end

  assign en = start_ok | stop_ok | cmd_resp | (|irq_clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cmd_q    <= 1'b0;
      xfr_q    <= 1'b0;
    end else if (en) begin
      active_q <= active_d;
      cmd_q    <= cmd_d;
      xfr_q    <= xfr_d;
    end
  end

  assign active   = active_q;
  assign irq_cmd  = cmd_q;
  assign irq_xfer = xfr_q;
endmodule

// File: rtl/dma_wreq_blk_seq.sv
module dma_wreq_blk_seq
  import dma_wreq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic             active,
  input  logic [CNT_W-1:0] blk_count,
  input  logic [WRD_W-1:0] words,
  input  logic             space_ok,
  input  logic             wr_valid,
  output logic             req,
  output logic             wr_acc
);
  logic             req_q,  req_d;
  logic             open_q, open_d;
  logic [WRD_W-1:0] wcnt_q, wcnt_d;
  logic [CNT_W-1:0] left_q, left_d;
  logic             launch, en;

  assign wr_acc = open_q & wr_valid;
  assign launch = active & ~open_q & (left_q != '0) & space_ok & ~stop;

  always_comb begin
    req_d  = req_q;
    open_d = open_q;
    wcnt_d = wcnt_q;
    left_d = left_q;
    if (stop) begin
      req_d  = 1'b0;
      open_d = 1'b0;
      wcnt_d = '0;
      left_d = '0;
    end else if (start) begin
      req_d  = 1'b0;
      open_d = 1'b0;
      wcnt_d = '0;
      left_d = blk_count;
    end else begin
      if (launch) begin
        req_d  = 1'b1;
        open_d = 1'b1;
        wcnt_d = '0;
        left_d = left_q - 1'b1;
      end
      if (wr_acc) begin
        req_d = 1'b0;
        if ((wcnt_q + 1'b1) == words) begin
          open_d = 1'b0;
          wcnt_d = '0;
        end else begin
          wcnt_d = wcnt_q + 1'b1;
        end
      end
    end
  end

  assign en = stop | start | launch | wr_acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      open_q <= 1'b0;
      wcnt_q <= '0;
      left_q <= '0;
    end else if (en) begin
      req_q  <= req_d;
      open_q <= open_d;
      wcnt_q <= wcnt_d;
      left_q <= left_d;
    end
  end

  assign req = req_q;
endmodule

// File: rtl/dma_wreq_level.sv
module dma_wreq_level #(
  parameter int DEPTH = 512,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             drain,
  output logic [LVL_W-1:0] level
);
  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic             dec, en;

  assign dec = drain & (lvl_q != '0);
  assign en  = inc ^ dec;

  always_comb begin
    lvl_d = lvl_q;
    if (inc && !dec)      lvl_d = lvl_q + 1'b1;
    else if (dec && !inc) lvl_d = lvl_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  lvl_q <= '0;
    else if (en) lvl_q <= lvl_d;
  end

  assign level = lvl_q;
endmodule

// File: rtl/dma_wreq_ctrl.sv
module dma_wreq_ctrl
  import dma_wreq_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int CNT_W = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BLEN_W-1:0] cfg_blk_bytes,
  input  logic [CNT_W-1:0]  cfg_blk_count,
  input  logic              cmd_start,
  input  logic              cmd_resp,
  input  logic              wr_valid,
  input  logic              drain,
  input  logic              xfer_done,
  input  logic [1:0]        irq_clr,
  output logic              dma_req_n,
  output logic              xfer_active,
  output logic [LVL_W-1:0]  buf_level,
  output logic              irq_cmd_done,
  output logic              irq_xfer_done
);
  logic             start_ok, stop_ok, active;
  logic [WRD_W-1:0] words;
  logic             space_ok, req, wr_acc;
  logic [LVL_W-1:0] level;

  assign words    = blk_words(cfg_blk_bytes);
  assign space_ok = (DEPTH - int'(level)) >= int'(words);

  dma_wreq_status u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_start (cmd_start),
    .cmd_resp  (cmd_resp),
    .xfer_done (xfer_done),
    .irq_clr   (irq_clr),
    .start_ok  (start_ok),
    .stop_ok   (stop_ok),
    .active    (active),
    .irq_cmd   (irq_cmd_done),
    .irq_xfer  (irq_xfer_done)
  );

  dma_wreq_blk_seq #(.CNT_W(CNT_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start_ok),
    .stop      (stop_ok),
    .active    (active),
    .blk_count (cfg_blk_count),
    .words     (words),
    .space_ok  (space_ok),
    .wr_valid  (wr_valid),
    .req       (req),
    .wr_acc    (wr_acc)
  );

  dma_wreq_level #(.DEPTH(DEPTH)) u_level (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (wr_acc),
    .drain (drain),
    .level (level)
  );

  assign dma_req_n   = ~req;
  assign xfer_active = active;
  assign buf_level   = level;
endmodule

// File: rtl/dma_wreq_checker.sv
module dma_wreq_checker
  import dma_wreq_pkg::*;
#(
  parameter int DEPTH = 512,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [BLEN_W-1:0] cfg_blk_bytes,
  input logic              wr_valid,
  input logic [1:0]        irq_clr,
  input logic              dma_req_n,
  input logic              xfer_active,
  input logic [LVL_W-1:0]  buf_level,
  input logic              irq_cmd_done,
  input logic              irq_xfer_done
);
  a_r2_req_needs_space: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dma_req_n) |->
      (DEPTH - int'($past(buf_level))) >= int'(blk_words($past(cfg_blk_bytes))));

  a_r3_drop_on_word: assert property (@(posedge clk) disable iff (!rst_n)
    (!dma_req_n && wr_valid) |=> dma_req_n);

  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    int'(buf_level) <= DEPTH);

  a_r6_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_level == $past(buf_level)) ||
    (buf_level == $past(buf_level) + 1'b1) ||
    (buf_level == $past(buf_level) - 1'b1));

  a_r8_req_only_active: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_req_n |-> xfer_active);

  a_r10_cmd_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_cmd_done && !irq_clr[0]) |=> irq_cmd_done);

  a_r10_xfer_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_xfer_done && !irq_clr[1]) |=> irq_xfer_done);
endmodule

bind dma_wreq_ctrl dma_wreq_checker #(.DEPTH(DEPTH)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_blk_bytes (cfg_blk_bytes),
  .wr_valid      (wr_valid),
  .irq_clr       (irq_clr),
  .dma_req_n     (dma_req_n),
  .xfer_active   (xfer_active),
  .buf_level     (buf_level),
  .irq_cmd_done  (irq_cmd_done),
  .irq_xfer_done (irq_xfer_done)
);

// File: tb/sim_dma_wreq_ctrl.sv
`timescale 1ns/1ps
module sim_dma_wreq_ctrl;
  localparam int DEPTH = 8;
  localparam int CNT_W = 16;
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic             clk;
  logic             rst_n;
  logic [10:0]      cfg_blk_bytes;
  logic [CNT_W-1:0] cfg_blk_count;
  logic             cmd_start, cmd_resp, wr_valid, drain, xfer_done;
  logic [1:0]       irq_clr;
  logic             dma_req_n, xfer_active, irq_cmd_done, irq_xfer_done;
  logic [LVL_W-1:0] buf_level;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  dma_wreq_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_blk_bytes(cfg_blk_bytes), .cfg_blk_count(cfg_blk_count),
    .cmd_start(cmd_start), .cmd_resp(cmd_resp), .wr_valid(wr_valid), .drain(drain),
    .xfer_done(xfer_done), .irq_clr(irq_clr), .dma_req_n(dma_req_n),
    .xfer_active(xfer_active), .buf_level(buf_level), .irq_cmd_done(irq_cmd_done),
    .irq_xfer_done(irq_xfer_done)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // All stimulus tasks start and end at a falling edge.
  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic p_start;  cmd_start = 1; tick(1); cmd_start = 0; endtask
  task automatic p_resp;   cmd_resp  = 1; tick(1); cmd_resp  = 0; endtask
  task automatic p_done;   xfer_done = 1; tick(1); xfer_done = 0; endtask
  task automatic p_drain;  drain     = 1; tick(1); drain     = 0; endtask
  task automatic p_wr(input int n);
    repeat (n) begin wr_valid = 1; tick(1); wr_valid = 0; end
  endtask
  task automatic p_clr(input logic [1:0] m); irq_clr = m; tick(1); irq_clr = 2'b00; endtask

  // Request must stay high for n sampled cycles.
  task automatic hold_high(input string tag, input int n);
    int lows = 0;
    repeat (n) begin tick(1); if (!dma_req_n) lows++; end
    chk(tag, lows, 0);
  endtask

  task automatic t_reset;
    chk("R1 req_n", dma_req_n, 1);
    chk("R1 active", xfer_active, 0);
    chk("R1 level", buf_level, 0);
    chk("R1 irq_cmd", irq_cmd_done, 0);
    chk("R1 irq_xfer", irq_xfer_done, 0);
    p_wr(2);
    chk("R7 idle write ignored", buf_level, 0);
    chk("R7 no request", dma_req_n, 1);
  endtask

  task automatic t_single;
    cfg_blk_bytes = 11'd16; cfg_blk_count = 1;
    p_start;
    chk("R8 active rises", xfer_active, 1);
    chk("R2 req not yet", dma_req_n, 1);
    tick(1);
    chk("R2 req low", dma_req_n, 0);
    p_wr(1);
    chk("R3 req drops on first word", dma_req_n, 1);
    chk("R6 level one", buf_level, 1);
    hold_high("R3 single request per block", 3);
    p_wr(3);
    chk("R6 level four", buf_level, 4);
    hold_high("R9 no request after last block", 5);
    p_resp;
    chk("R10 cmd flag set", irq_cmd_done, 1);
    p_done;
    chk("R8 active falls", xfer_active, 0);
    chk("R10 xfer flag set", irq_xfer_done, 1);
    tick(3);
    chk("R10 cmd flag sticky", irq_cmd_done, 1);
    p_clr(2'b01);
    chk("R10 clr bit0", irq_cmd_done, 0);
    chk("R10 bit0 keeps xfer", irq_xfer_done, 1);
    p_clr(2'b10);
    chk("R10 clr bit1", irq_xfer_done, 0);
    repeat (4) p_drain;
    chk("R6 drained", buf_level, 0);
    p_drain;
    chk("R6 no underflow", buf_level, 0);
  endtask

  task automatic t_multi;
    cfg_blk_bytes = 11'd10; cfg_blk_count = 3;   // 3 words per block
    p_start;
    tick(1);
    chk("R2 first request", dma_req_n, 0);
    p_wr(2);
    hold_high("R4 masked short of block", 4);
    p_wr(1);
    chk("R4 level after block", buf_level, 3);
    chk("R4 not same edge", dma_req_n, 1);
    tick(1);
    chk("R4 next request", dma_req_n, 0);
    p_wr(3);
    chk("R6 level six", buf_level, 6);
    hold_high("R5 masked on space", 4);
    p_drain;
    chk("R5 level after drain", buf_level, 5);
    chk("R5 not same edge", dma_req_n, 1);
    tick(1);
    chk("R5 request after room", dma_req_n, 0);
    p_wr(3);
    chk("R6 full", buf_level, DEPTH);
    p_wr(1);
    chk("R7 extra write ignored", buf_level, DEPTH);
    repeat (DEPTH) p_drain;
    chk("R6 empty", buf_level, 0);
    hold_high("R9 count reached", 4);
    cmd_resp = 1; irq_clr = 2'b01; tick(1); cmd_resp = 0; irq_clr = 2'b00;
    chk("R10 set beats clear", irq_cmd_done, 1);
    p_done;
    p_clr(2'b11);
    chk("R10 all cleared", int'({irq_cmd_done, irq_xfer_done}), 0);
  endtask

  task automatic t_zero_count;
    cfg_blk_bytes = 11'd4; cfg_blk_count = 0;
    p_start;
    chk("R8 active zero count", xfer_active, 1);
    hold_high("R9 zero count no request", 5);
    p_done;
    chk("R8 done clears", xfer_active, 0);
    p_resp;
    chk("R10 resp ignored idle", irq_cmd_done, 0);
    p_clr(2'b11);
  endtask

  initial begin
    rst_n = 0; cmd_start = 0; cmd_resp = 0; wr_valid = 0; drain = 0;
    xfer_done = 0; irq_clr = 0; cfg_blk_bytes = 11'd16; cfg_blk_count = 1;
    tick(3);
    rst_n = 1;
    tick(1);
    t_reset;
    t_single;
    t_multi;
    t_zero_count;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule